// File: doc/BRIEF.md
# Shared Target Bus Arbiter

This block decides which of four masters may drive a single shared target bus. The masters are a CPU, a coprocessor, a DMA engine belonging to a communication controller, and a debug master. Each master raises a request, receives a grant, and signals done when its access ends. The arbiter keeps at most one grant active at a time. It keeps that grant until the holder signals done, and then releases the bus for one idle cycle before it arbitrates again.

The winner comes from a fixed ranking, and the ranking depends on the request type. The DMA engine can mark a request as high priority, and that request then ranks above the CPU. The coprocessor can flag an access as aimed at a special register region. Such an access wins every arbitration, and it also takes the bus away from a CPU that is holding it, so the CPU stalls while the coprocessor access runs. A debug request that has been stalled for more than a set number of cycles is promoted to the top of the normal ranking. The promotion takes effect at the next arbitration, once the current holder has finished.

Every master that is requesting but not granted sees a registered stall flag.

Top module: `bus_arbiter`

## Requirements
- R1: The grant vector is one-hot or all zero. With no request pending, the bus stays idle and no master is granted.
- R2: Bit positions are fixed: bit 0 is the CPU, bit 1 the coprocessor, bit 2 the DMA engine and bit 3 the debug master. Among normal requests the CPU ranks above the coprocessor, the coprocessor above the DMA engine, and the DMA engine above the debug master.
- R3: A DMA request with `dma_hi_i`=1 ranks above the CPU, above a coprocessor request that is not flagged special, and above a debug request that has not been promoted.
- R4: A request seen while the bus is idle is granted on the next clock edge. A grant then holds until its owner raises done, and a coprocessor special request does not take the bus from a holder other than the CPU.
- R5: On the edge that follows a done from the grant holder, all grants drop to zero. Arbitration happens again on the next edge.
- R6: A coprocessor request with `cop_spc_i`=1 wins arbitration over every other request, including a high-priority DMA request and a promoted debug request.
- R7: While the CPU holds the bus and has not raised done, a special coprocessor request moves the grant to the coprocessor on the next edge. The CPU then shows stall for as long as its request stays pending.
- R8: `stall_o` is registered. After each edge it equals the request vector sampled at that edge, masked by the inverse of the new grant vector.
- R9: A debug request that has been pending and ungranted for more than STARVE_LIMIT cycles ranks above the CPU and above high-priority DMA at the next arbitration. It does not cut short the current holder.
- R10: The debug wait count returns to zero whenever the debug request is withdrawn or granted, and it saturates instead of wrapping.
- R11: While reset is asserted, all grant and stall outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Requests, one bit per master |
| done_i | input | 4 | End of access, one bit per master |
| dma_hi_i | input | 1 | DMA request is high priority |
| cop_spc_i | input | 1 | Coprocessor request targets the special register region |
| gnt_o | output | 4 | Registered grant, one-hot or zero |
| stall_o | output | 4 | Registered stall, set for masters requesting without a grant |

## Verification
The bench builds the arbiter with STARVE_LIMIT at its default of 128 and COP_PREEMPT at 1. At those values the real promotion threshold is exercised, and the preemption path is actually instantiated. Three starvation windows are driven against that threshold. A 20-cycle wait stays well below it. A 100-cycle wait followed by a withdrawal and another 50 cycles would cross the threshold only if the count failed to clear. A 140-cycle wait crosses it. Together these separate promotion from ordinary ranking and from a counter that fails to reset.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
   localparam int NUM_MASTERS = 4;
   localparam int IDX_CPU = 0;
   localparam int IDX_COP = 1;
   localparam int IDX_DMA = 2;
   localparam int IDX_DBG = 3;
   typedef logic [NUM_MASTERS-1:0] mvec_t;
endpackage

// File: rtl/arb_starve_ctr.sv
module arb_starve_ctr #(
   parameter int LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting,
   input  logic clear,
   output logic promote
);
   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("arb_starve_ctr: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (waiting && (cnt_q != SAT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign promote = (cnt_q == SAT);
endmodule

// File: rtl/arb_pick.sv
module arb_pick
   import bus_arb_pkg::*;
(
   input  mvec_t req,
   input  logic  dma_hi,
   input  logic  cop_spc,
   input  logic  dbg_promo,
   output mvec_t pick
);
   always_comb begin
      pick = '0;
      if (req[IDX_COP] && cop_spc)      pick[IDX_COP] = 1'b1;
      else if (req[IDX_DBG] && dbg_promo) pick[IDX_DBG] = 1'b1;
      else if (req[IDX_DMA] && dma_hi)  pick[IDX_DMA] = 1'b1;
      else if (req[IDX_CPU])            pick[IDX_CPU] = 1'b1;
      else if (req[IDX_COP])            pick[IDX_COP] = 1'b1;
      else if (req[IDX_DMA])            pick[IDX_DMA] = 1'b1;
      else if (req[IDX_DBG])            pick[IDX_DBG] = 1'b1;
   end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
   import bus_arb_pkg::*;
#(
   parameter int STARVE_LIMIT = 128,
   parameter bit COP_PREEMPT  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] req_i,
   input  logic [3:0] done_i,
   input  logic       dma_hi_i,
   input  logic       cop_spc_i,
   output logic [3:0] gnt_o,
   output logic [3:0] stall_o
);
   mvec_t gnt_q, stall_q, gnt_nxt, pick;
   logic  dbg_promo, busy, holder_done, preempt;

   arb_starve_ctr #(.LIMIT(STARVE_LIMIT)) i_starve (
      .clk     (clk),
      .rst_n   (rst_n),
      .waiting (req_i[IDX_DBG] & ~gnt_q[IDX_DBG]),
      .clear   (~req_i[IDX_DBG] | gnt_q[IDX_DBG]),
      .promote (dbg_promo)
   );

   arb_pick i_pick (
      .req       (req_i),
      .dma_hi    (dma_hi_i),
      .cop_spc   (cop_spc_i),
      .dbg_promo (dbg_promo),
      .pick      (pick)
   );

   assign busy        = |gnt_q;
   assign holder_done = |(gnt_q & done_i);

   generate
      if (COP_PREEMPT) begin : g_preempt
         assign preempt = gnt_q[IDX_CPU] & ~done_i[IDX_CPU]
                        & req_i[IDX_COP] & cop_spc_i;
      end else begin : g_no_preempt
         assign preempt = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!busy) begin
         gnt_nxt = pick;
      end else if (holder_done) begin
         gnt_nxt = '0;
      end else if (preempt) begin
         gnt_nxt = '0;
         gnt_nxt[IDX_COP] = 1'b1;
      end else begin
         gnt_nxt = gnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q   <= '0;
         stall_q <= '0;
      end else begin
         gnt_q   <= gnt_nxt;
         stall_q <= req_i & ~gnt_nxt;
      end
   end

   assign gnt_o   = gnt_q;
   assign stall_o = stall_q;
endmodule

module bus_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] req_i,
   input logic [3:0] done_i,
   input logic       cop_spc_i,
   input logic [3:0] gnt_o,
   input logic [3:0] stall_o
);
   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R1
   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o == 4'b0 && req_i == 4'b0) |=> gnt_o == 4'b0); // R1
   AST_HOLD_NON_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt_o[3:1] & ~done_i[3:1])) |=> $stable(gnt_o)); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt_o & done_i)) |=> gnt_o == 4'b0); // R5
   AST_CPU_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o[0] && !done_i[0] && req_i[1] && cop_spc_i) |=> gnt_o[1]); // R7
   AST_STALL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> stall_o == ($past(req_i) & ~gnt_o)); // R8
endmodule

bind bus_arbiter bus_arbiter_chk i_bus_arbiter_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .done_i    (done_i),
   .cop_spc_i (cop_spc_i),
   .gnt_o     (gnt_o),
   .stall_o   (stall_o)
);

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] req = '0, done = '0;
   logic       hi = 1'b0, spc = 1'b0;
   logic [3:0] gnt, stall;
   int         cyc = 0;
   int         n_chk = 0, n_fail = 0;
   bit         drained = 1'b0;

   typedef struct {
      int         due;
      logic [3:0] eg;
      logic [3:0] es;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bus_arbiter i_bus_arbiter (
      .clk (clk), .rst_n (rst_n), .req_i (req), .done_i (done),
      .dma_hi_i (hi), .cop_spc_i (spc), .gnt_o (gnt), .stall_o (stall)
   );

   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (gnt !== e.eg || stall !== e.es) begin
            n_fail++;
            $display("FAIL %s: gnt=%b stall=%b expected gnt=%b stall=%b",
                     e.tag, gnt, stall, e.eg, e.es);
         end
      end
   end

   task automatic drv(input logic [3:0] r, input logic [3:0] d,
                      input logic h, input logic s,
                      input logic [3:0] eg, input logic [3:0] es,
                      input string tag);
      @(posedge clk);
      #2;
      req = r; done = d; hi = h; spc = s;
      if (tag != "") q.push_back('{cyc + 1, eg, es, tag});
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (gnt !== 4'b0 || stall !== 4'b0) begin
         n_fail++;
         $display("FAIL R11: gnt=%b stall=%b expected gnt=0000 stall=0000", gnt, stall);
      end
      rst_n = 1'b1;

      drv(4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0000, "R1 idle no owner");
      // R2 ranking and R4 hold
      drv(4'b0101, 4'b0000, 0, 0, 4'b0001, 4'b0100, "R2 cpu over dma");
      drv(4'b0101, 4'b0001, 0, 0, 4'b0000, 4'b0101, "R5 release");
      drv(4'b0101, 4'b0000, 1, 0, 4'b0100, 4'b0001, "R3 dma high over cpu");
      drv(4'b0111, 4'b0000, 1, 1, 4'b0100, 4'b0011, "R4 dma holder kept vs cop special");
      drv(4'b0111, 4'b0100, 0, 0, 4'b0000, 4'b0111, "R5 release dma");
      drv(4'b0111, 4'b0000, 0, 0, 4'b0001, 4'b0110, "R2 cpu first");
      drv(4'b0110, 4'b0001, 0, 0, 4'b0000, 4'b0110, "R5 release cpu");
      drv(4'b0110, 4'b0000, 0, 0, 4'b0010, 4'b0100, "R2 cop over dma normal");
      drv(4'b1100, 4'b0010, 0, 0, 4'b0000, 4'b1100, "R5 release cop");
      drv(4'b1100, 4'b0000, 0, 0, 4'b0100, 4'b1000, "R2 dma over dbg");
      drv(4'b1000, 4'b0100, 0, 0, 4'b0000, 4'b1000, "R5 release");
      drv(4'b1000, 4'b0000, 0, 0, 4'b1000, 4'b0000, "R2 dbg alone");
      drv(4'b0000, 4'b1000, 0, 0, 4'b0000, 4'b0000, "R5 release dbg");
      // R6 special cop from idle
      drv(4'b1111, 4'b0000, 1, 1, 4'b0010, 4'b1101, "R6 cop special wins");
      drv(4'b0000, 4'b0010, 0, 0, 4'b0000, 4'b0000, "R5 release");
      // R7 preemption of cpu
      drv(4'b0001, 4'b0000, 0, 0, 4'b0001, 4'b0000, "R4 cpu granted");
      drv(4'b0011, 4'b0000, 0, 0, 4'b0001, 4'b0010, "R4 cop normal waits");
      drv(4'b0011, 4'b0000, 0, 1, 4'b0010, 4'b0001, "R7 cop preempts cpu");
      drv(4'b0011, 4'b0000, 0, 1, 4'b0010, 4'b0001, "R7 cpu stalled");
      drv(4'b0001, 4'b0010, 0, 0, 4'b0000, 4'b0001, "R8 cpu stall in release");
      drv(4'b0001, 4'b0000, 0, 0, 4'b0001, 4'b0000, "R7 cpu resumes");
      // R9 negative: short debug wait
      for (int i = 0; i < 20; i++) drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "");
      drv(4'b1001, 4'b0001, 0, 0, 4'b0000, 4'b1001, "R5 release");
      drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "R9 short wait no promotion");
      drv(4'b0001, 4'b0000, 0, 0, 4'b0001, 4'b0000, "R8 dbg withdrawn");
      // R10 withdrawal clears the count
      for (int i = 0; i < 100; i++) drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "");
      drv(4'b0001, 4'b0000, 0, 0, 4'b0001, 4'b0000, "R10 withdraw");
      for (int i = 0; i < 50; i++) drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "");
      drv(4'b1001, 4'b0001, 0, 0, 4'b0000, 4'b1001, "R5 release");
      drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "R10 count cleared, cpu wins");
      // R9 positive: long debug wait
      for (int i = 0; i < 140; i++) drv(4'b1001, 4'b0000, 0, 0, 4'b0001, 4'b1000, "");
      drv(4'b1101, 4'b0000, 1, 0, 4'b0001, 4'b1100, "R9 holder not cut short");
      drv(4'b1101, 4'b0001, 1, 0, 4'b0000, 4'b1101, "R5 release");
      drv(4'b1101, 4'b0000, 1, 0, 4'b1000, 4'b0101, "R9 dbg promoted");
      drv(4'b0000, 4'b1000, 0, 0, 4'b0000, 4'b0000, "R5 release dbg");
      drv(4'b0000, 4'b0000, 0, 0, 4'b0000, 4'b0000, "R1 idle again");
      repeat (3) @(posedge clk);
      drained = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule